// File: doc/BRIEF.md
# Segment Line Output Latch

This block sits between the display frame memory and the segment drivers of a passive-matrix panel controller. Once per display line, the timing generator raises a one-cycle line strobe. On that strobe the block captures the line word that has been read out of frame memory. It holds that copy for the whole line period, so the drivers never see the memory port. Processor traffic to the frame memory therefore cannot disturb the picture that is being scanned.

The block also applies three presentation controls on its way to the segment outputs: panel blanking, forced fill, and inverted video. These controls act only on the held copy. They never write back into the stored line or into frame memory. Clearing a control restores the original picture at once, without waiting for a new line. The output vector is registered, and a control change is visible one clock after it is applied, with no strobe needed.

Top module: `seg_line_latch`

## Requirements
- R1: While `rst` is high, `seg_out` becomes all zeros at the next clock edge and the held line is cleared to zeros. A strobe during reset is not captured.
- R2: When `line_stb` is high at a clock edge, `line_data` is captured, and `seg_out` shows it from that same edge, filtered by the current controls.
- R3: When `line_stb` is low, changes on `line_data` have no effect on `seg_out`.
- R4: With `disp_en`=1, `fill`=0 and `invert`=1, `seg_out` is the bitwise complement of the held line.
- R5: With `disp_en`=1 and `fill`=1, every bit of `seg_out` is 1, whatever `invert` is.
- R6: With `disp_en`=0, every bit of `seg_out` is 0, whatever `fill` and `invert` are. Blanking has the highest priority.
- R7: A control change reaches `seg_out` one clock edge later without a strobe. The held line survives any sequence of control changes, so returning to normal mode (`disp_en`=1, `fill`=0, `invert`=0) shows it unchanged.
- R8: When a strobe and a control change fall in the same cycle, `seg_out` after that edge is the new line filtered by the new controls. A line captured while blanked or filled is held and is shown once normal mode returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle line capture strobe |
| line_data | input | SEG_W | Line word read from frame memory |
| disp_en | input | 1 | 1 = panel shown, 0 = all segments off |
| fill | input | 1 | 1 = all segments forced on |
| invert | input | 1 | 1 = inverted video |
| seg_out | output | SEG_W | Registered per-segment on/off vector |

## Verification
Line capture and a control change can land on the same clock edge. This happens when the strobe is raised in the same cycle that `invert` is set or `disp_en` is cleared. The bench provokes this by driving both together in its vector table. It judges the result by requiring the new word in the new mode right after that edge. Later vectors return to normal mode and check that a word captured while blanked was held, not lost.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    MODE_BLANK  = 2'd0,
    MODE_FILL   = 2'd1,
    MODE_INVERT = 2'd2,
    MODE_PASS   = 2'd3
  } seg_mode_e;

endpackage

// File: rtl/seg_mode_decode.sv
module seg_mode_decode
  import seg_pkg::*;
(
  input  logic      disp_en,
  input  logic      fill,
  input  logic      invert,
  output seg_mode_e mode
);

  // Blanking beats fill, fill beats inversion.
  always_comb begin
    if (!disp_en)    mode = MODE_BLANK;
    else if (fill)   mode = MODE_FILL;
    else if (invert) mode = MODE_INVERT;
    else             mode = MODE_PASS;
  end

endmodule

// File: rtl/seg_line_store.sv
module seg_line_store #(
  parameter int SEG_W = 132
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [SEG_W-1:0] din,
  output logic [SEG_W-1:0] held_nxt
);

  logic [SEG_W-1:0] held_q;

  // Value the store will hold after this edge.
  assign held_nxt = stb ? din : held_q;

  always_ff @(posedge clk) begin
    if (rst) held_q <= '0;
    else     held_q <= held_nxt;
  end

endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_pkg::*;
#(
  parameter int SEG_W = 132
) (
  input  logic             clk,
  input  logic             rst,
  input  seg_mode_e        mode,
  input  logic [SEG_W-1:0] line,
  output logic [SEG_W-1:0] seg_q
);

  logic [SEG_W-1:0] seg_d;

  for (genvar i = 0; i < SEG_W; i++) begin : g_seg
    always_comb begin
      unique case (mode)
        MODE_BLANK:  seg_d[i] = 1'b0;
        MODE_FILL:   seg_d[i] = 1'b1;
        MODE_INVERT: seg_d[i] = ~line[i];
        default:     seg_d[i] = line[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) seg_q <= '0;
    else     seg_q <= seg_d;
  end

endmodule

// File: rtl/seg_line_latch.sv
module seg_line_latch
  import seg_pkg::*;
#(
  parameter int SEG_W = 132
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_stb,
  input  logic [SEG_W-1:0] line_data,
  input  logic             disp_en,
  input  logic             fill,
  input  logic             invert,
  output logic [SEG_W-1:0] seg_out
);

  logic [SEG_W-1:0] held_nxt;
  seg_mode_e        mode;

  seg_line_store #(.SEG_W(SEG_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .stb      (line_stb),
    .din      (line_data),
    .held_nxt (held_nxt)
  );

  seg_mode_decode u_dec (
    .disp_en (disp_en),
    .fill    (fill),
    .invert  (invert),
    .mode    (mode)
  );

  seg_out_stage #(.SEG_W(SEG_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .line  (held_nxt),
    .seg_q (seg_out)
  );

endmodule

// File: rtl/seg_line_latch_chk.sv
module seg_line_latch_chk #(
  parameter int SEG_W = 132
) (
  input logic             clk,
  input logic             rst,
  input logic             line_stb,
  input logic [SEG_W-1:0] line_data,
  input logic             disp_en,
  input logic             fill,
  input logic             invert,
  input logic [SEG_W-1:0] seg_out
);

  // Reference copy of the line, kept from port activity only.
  logic [SEG_W-1:0] ref_line;
  always_ff @(posedge clk) begin
    if (rst)           ref_line <= '0;
    else if (line_stb) ref_line <= line_data;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> seg_out == '0);

  // R2, R3, R7: the normal path shows the reference copy.
  assert_pass_matches_R2: assert property (@(posedge clk) disable iff (rst)
    (disp_en && !fill && !invert) |=> seg_out == ref_line);

  assert_invert_R4: assert property (@(posedge clk) disable iff (rst)
    (disp_en && !fill && invert) |=> seg_out == ~ref_line);

  assert_fill_R5: assert property (@(posedge clk) disable iff (rst)
    (disp_en && fill) |=> &seg_out);

  assert_blank_R6: assert property (@(posedge clk) disable iff (rst)
    !disp_en |=> seg_out == '0);

endmodule

bind seg_line_latch seg_line_latch_chk #(.SEG_W(SEG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .line_stb  (line_stb),
  .line_data (line_data),
  .disp_en   (disp_en),
  .fill      (fill),
  .invert    (invert),
  .seg_out   (seg_out)
);

// File: tb/seg_line_latch_test.sv
module seg_line_latch_test;

  localparam int W  = 16;
  localparam int NV = 11;
  localparam int VW = 2*W + 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         line_stb = 1'b0;
  logic [W-1:0] line_data = '0;
  logic         disp_en = 1'b1;
  logic         fill = 1'b0;
  logic         invert = 1'b0;
  logic [W-1:0] seg_out;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  seg_line_latch #(.SEG_W(W)) uut (
    .clk(clk), .rst(rst), .line_stb(line_stb), .line_data(line_data),
    .disp_en(disp_en), .fill(fill), .invert(invert), .seg_out(seg_out)
  );

  // {stb, data, disp_en, fill, invert, expected}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 16'hA5C3, 1'b1, 1'b0, 1'b0, 16'hA5C3}, // R2 capture
    {1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 16'hA5C3}, // R3 no strobe
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h5A3C}, // R4 invert, R7
    {1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hFFFF}, // R5 fill over invert
    {1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0000}, // R6 blank over all
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'hA5C3}, // R7 held line kept
    {1'b1, 16'h1234, 1'b1, 1'b0, 1'b1, 16'hEDCB}, // R8 strobe + invert
    {1'b1, 16'h0F0F, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8 strobe + blank
    {1'b0, 16'h5555, 1'b1, 1'b0, 1'b0, 16'h0F0F}, // R8 captured while off
    {1'b1, 16'hFFFF, 1'b1, 1'b1, 1'b0, 16'hFFFF}, // R5 strobe + fill
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0000}  // R4 complement of FFFF
  };

  task automatic check(input string req, input logic [W-1:0] exp);
    tests++;
    if (seg_out !== exp) begin
      fails++;
      $display("FAIL %s: seg_out=%h expected=%h", req, seg_out, exp);
    end
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1", '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      line_stb  = VEC[i][VW-1];
      line_data = VEC[i][VW-2 -: W];
      disp_en   = VEC[i][W+2];
      fill      = VEC[i][W+1];
      invert    = VEC[i][W];
      @(negedge clk);
      check($sformatf("vector %0d R2-table", i), VEC[i][W-1:0]);
    end

    // R1: reset with strobe active must clear and not capture
    line_stb = 1'b1; line_data = 16'hBEEF;
    disp_en = 1'b1; fill = 1'b0; invert = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 out", '0);
    rst = 1'b0; line_stb = 1'b0; line_data = 16'hFFFF;
    @(negedge clk);
    check("R1 held cleared", '0);
    invert = 1'b1;
    @(negedge clk);
    check("R1 cleared inverted", 16'hFFFF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule